// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a four-bank SDRAM command interface and, on every rising clock edge, names the command the pins encode. It also keeps an idle or active state for each bank and judges each command against that state. Its outputs are registered: one clock after the sampling edge they give the command as a one-hot bus, the bank the command addresses, a flag for a command that is not allowed in the current bank state, and the auto-precharge and precharge-all options carried on the A10 address bit.

Auto-precharge is modelled with a completion count supplied on an input when the read or write is issued. The bank stays active for that many further clock edges and then returns to idle by itself. The block is meant for a memory-controller monitor, a protocol checker or a device model that must know which banks are open. It does not check timing parameters, carry data, or model power-down and self-refresh beyond naming them.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With CKE high in the previous cycle and chip select low, the pins (ras_n, cas_n, we_n) decode as: 0,1,1 activate; 1,0,1 read; 1,0,0 write; 0,1,0 precharge; 1,1,0 burst stop; 0,0,0 mode set; 0,0,1 with CKE high refresh; 1,1,1 with CKE high no-op. The one-hot bit positions are deselect 0, no-op 1, activate 2, read 3, write 4, precharge 5, burst stop 6, mode set 7, refresh 8, self-refresh entry 9, power-down entry 10, held 11; exactly one bit is set every cycle.
- R2: Chip select high with CKE high decodes as deselect. Deselect, no-op, precharge, burst stop and held are never flagged illegal.
- R3: With CKE high in the previous cycle and low now, 0,0,1 decodes as self-refresh entry, and no-op or chip select high decodes as power-down entry. With CKE low in the previous cycle the command is held: pins are ignored and bank states are not changed by them.
- R4: Each output reflects the pins sampled at one edge and appears after that edge; cmd_bank always equals the sampled ba.
- R5: Activate to an idle bank makes it active; activate to an active bank is illegal and does not change any bank.
- R6: Read or write to an idle bank is illegal and leaves the bank idle.
- R7: autopre is set for read or write with A10 high. A legal read or write with A10 high and count N keeps the bank active until, and clears it at, the N-th edge after the sampling edge; N of zero acts as one.
- R8: Precharge with A10 low idles only the addressed bank; with A10 high it idles every bank and pre_all is set. Precharge to an idle bank is legal.
- R9: Refresh, mode set, self-refresh entry and power-down entry are illegal while any bank is active, and none of these changes bank state.
- R10: A legal read or write with A10 low, or a precharge, to a bank with auto-precharge pending cancels the pending countdown.
- R11: Reset (synchronous, active high) idles all banks, presents the no-op bit on cmd_onehot, clears all flags and treats the previous CKE as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all option bit |
| burst_len | input | CNT_W (8) | Auto-precharge completion count |
| cmd_onehot | output | 12 | Decoded command, one-hot |
| cmd_bank | output | BA_W (2) | Bank the command addresses |
| illegal | output | 1 | Command not allowed in current bank state |
| autopre | output | 1 | Read or write with auto-precharge |
| pre_all | output | 1 | Precharge of all banks |
| bank_active | output | NUM_BANKS (4) | Active bit per bank |

## Verification
The assertions watch every cycle for a one-hot command bus, flags that only accompany their commands, and bank bits consistent with each reported command: a legal activate leaves its bank active, an illegal read or write finds its bank idle, precharges leave the right banks idle, and legal refresh or mode set finds all banks idle. Whether a countdown expires at exactly the N-th edge, whether a later read cancels it, and whether held cycles ignore their pins depend on history several commands deep, so only the bench's directed scenarios and its reference model over random traffic show them.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  localparam int NUM_CMDS = 12;

  typedef enum logic [3:0] {
    C_DESEL = 4'd0,
    C_NOP   = 4'd1,
    C_ACT   = 4'd2,
    C_READ  = 4'd3,
    C_WRITE = 4'd4,
    C_PRE   = 4'd5,
    C_TERM  = 4'd6,
    C_MRS   = 4'd7,
    C_REFA  = 4'd8,
    C_SREF  = 4'd9,
    C_PDN   = 4'd10,
    C_HOLD  = 4'd11
  } cmd_e;
endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  output cmd_e cmd
);
  logic cke_prev;

  // R3: previous CKE level, high out of reset (R11)
  always_ff @(posedge clk) begin
    if (rst) cke_prev <= 1'b1;
    else     cke_prev <= cke;
  end

  always_comb begin
    cmd = C_NOP;
    if (!cke_prev) begin
      cmd = C_HOLD;
    end else if (cs_n) begin
      cmd = cke ? C_DESEL : C_PDN;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = cke ? C_NOP : C_PDN;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_READ;
        3'b100:  cmd = C_WRITE;
        3'b010:  cmd = C_PRE;
        3'b110:  cmd = C_TERM;
        3'b000:  cmd = C_MRS;
        3'b001:  cmd = cke ? C_REFA : C_SREF;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_trk_legal.sv
module sdram_trk_legal
  import sdram_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic [NUM_BANKS-1:0] bank_active,
  output logic                 legal
);
  logic any_active;
  logic sel_active;

  assign any_active = |bank_active;
  assign sel_active = bank_active[ba];

  always_comb begin
    case (cmd)
      C_ACT:                       legal = !sel_active;   // R5
      C_READ, C_WRITE:             legal = sel_active;    // R6
      C_REFA, C_MRS, C_SREF, C_PDN: legal = !any_active;  // R9
      default:                     legal = 1'b1;          // R2
    endcase
  end
endmodule

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank
  import sdram_trk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             legal,
  input  cmd_e             cmd,
  input  logic             a10,
  input  logic [CNT_W-1:0] burst_len,
  output logic             active
);
  logic             pending;
  logic [CNT_W-1:0] cnt;
  logic             do_pre, do_act, do_rw;

  always_comb begin
    do_pre = legal && (cmd == C_PRE) && (a10 || hit);
    do_act = legal && (cmd == C_ACT) && hit;
    do_rw  = legal && ((cmd == C_READ) || (cmd == C_WRITE)) && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      pending <= 1'b0;
      cnt     <= '0;
    end else if (do_pre) begin          // R8, R10
      active  <= 1'b0;
      pending <= 1'b0;
    end else if (do_act) begin          // R5
      active  <= 1'b1;
    end else if (do_rw) begin
      if (a10) begin                    // R7
        pending <= 1'b1;
        cnt     <= (burst_len == '0) ? CNT_W'(1) : burst_len;
      end else begin                    // R10
        pending <= 1'b0;
      end
    end else if (pending) begin
      if (cnt <= CNT_W'(1)) begin
        active  <= 1'b0;
        pending <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int CNT_W     = 8,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  logic [CNT_W-1:0]     burst_len,
  output logic [NUM_CMDS-1:0]  cmd_onehot,
  output logic [BA_W-1:0]      cmd_bank,
  output logic                 illegal,
  output logic                 autopre,
  output logic                 pre_all,
  output logic [NUM_BANKS-1:0] bank_active
);
  localparam logic [NUM_CMDS-1:0] ONE = {{(NUM_CMDS-1){1'b0}}, 1'b1};

  cmd_e cmd;
  logic legal;

  sdram_trk_decode u_decode (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cke   (cke),
    .cmd   (cmd)
  );

  sdram_trk_legal #(.NUM_BANKS(NUM_BANKS)) u_legal (
    .cmd         (cmd),
    .ba          (ba),
    .bank_active (bank_active),
    .legal       (legal)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_trk_bank #(.CNT_W(CNT_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .hit       (ba == BA_W'(b)),
      .legal     (legal),
      .cmd       (cmd),
      .a10       (a10),
      .burst_len (burst_len),
      .active    (bank_active[b])
    );
  end

  // R4: registered command report
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_onehot <= ONE << C_NOP;
      cmd_bank   <= '0;
      illegal    <= 1'b0;
      autopre    <= 1'b0;
      pre_all    <= 1'b0;
    end else begin
      cmd_onehot <= ONE << cmd;
      cmd_bank   <= ba;
      illegal    <= !legal;
      autopre    <= a10 && ((cmd == C_READ) || (cmd == C_WRITE));
      pre_all    <= a10 && (cmd == C_PRE);
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int CNT_W     = 8,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CMDS-1:0]  cmd_onehot,
  input logic [BA_W-1:0]      cmd_bank,
  input logic                 illegal,
  input logic                 autopre,
  input logic                 pre_all,
  input logic [NUM_BANKS-1:0] bank_active
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd_onehot) == 1);

  a_r2_never_illegal: assert property (@(posedge clk) disable iff (rst)
    (cmd_onehot[C_DESEL] || cmd_onehot[C_NOP] || cmd_onehot[C_PRE] ||
     cmd_onehot[C_TERM] || cmd_onehot[C_HOLD]) |-> !illegal);

  a_r5_act_opens: assert property (@(posedge clk) disable iff (rst)
    (cmd_onehot[C_ACT] && !illegal) |-> bank_active[cmd_bank]);

  a_r6_rw_idle: assert property (@(posedge clk) disable iff (rst)
    ((cmd_onehot[C_READ] || cmd_onehot[C_WRITE]) && illegal) |-> !bank_active[cmd_bank]);

  a_r7_autopre_flag: assert property (@(posedge clk) disable iff (rst)
    autopre |-> (cmd_onehot[C_READ] || cmd_onehot[C_WRITE]));

  a_r8_pre_all: assert property (@(posedge clk) disable iff (rst)
    (cmd_onehot[C_PRE] && pre_all) |-> (bank_active == '0));

  a_r8_pre_one: assert property (@(posedge clk) disable iff (rst)
    cmd_onehot[C_PRE] |-> !bank_active[cmd_bank]);

  a_r8_pre_all_flag: assert property (@(posedge clk) disable iff (rst)
    pre_all |-> cmd_onehot[C_PRE]);

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    ((cmd_onehot[C_MRS] || cmd_onehot[C_REFA] || cmd_onehot[C_SREF] ||
      cmd_onehot[C_PDN]) && !illegal) |-> (bank_active == '0));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_onehot  (cmd_onehot),
  .cmd_bank    (cmd_bank),
  .illegal     (illegal),
  .autopre     (autopre),
  .pre_all     (pre_all),
  .bank_active (bank_active)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic        a10 = 1'b0;
  logic [7:0]  burst_len = '0;
  logic [11:0] cmd_onehot;
  logic [1:0]  cmd_bank;
  logic        illegal, autopre, pre_all;
  logic [3:0]  bank_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit m_act [4];
  bit m_pend[4];
  int m_cnt [4];
  bit m_ckep;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_tracker u_sdram_cmd_tracker (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .a10(a10), .burst_len(burst_len),
    .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank), .illegal(illegal),
    .autopre(autopre), .pre_all(pre_all), .bank_active(bank_active)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int decode(bit ckep, bit cs, bit r, bit c, bit w, bit ck);
    if (!ckep) return 11;
    if (cs) return ck ? 0 : 10;
    case ({r, c, w})
      3'b111: return ck ? 1 : 10;
      3'b011: return 2;
      3'b101: return 3;
      3'b100: return 4;
      3'b010: return 5;
      3'b110: return 6;
      3'b000: return 7;
      default: return ck ? 8 : 9;
    endcase
  endfunction

  function automatic bit any_open();
    for (int i = 0; i < 4; i++) if (m_act[i]) return 1;
    return 0;
  endfunction

  // one command: drive at falling edge, update model, check after rising edge
  task automatic cyc(string tag, bit cs, bit r, bit c, bit w, bit ck,
                     int b, bit a, int bl);
    int  cmd;
    bit  ok;
    bit  exp_ap, exp_pa;
    logic [3:0] exp_act;
    @(negedge clk);
    cs_n = cs; ras_n = r; cas_n = c; we_n = w; cke = ck;
    ba = 2'(b); a10 = a; burst_len = 8'(bl);
    cmd = decode(m_ckep, cs, r, c, w, ck);
    case (cmd)
      2:       ok = !m_act[b];
      3, 4:    ok = m_act[b];
      7, 8, 9, 10: ok = !any_open();
      default: ok = 1;
    endcase
    exp_ap = a && (cmd == 3 || cmd == 4);
    exp_pa = a && (cmd == 5);
    for (int i = 0; i < 4; i++) begin
      bit hit = (i == b);
      if (ok && cmd == 5 && (a || hit)) begin
        m_act[i] = 0; m_pend[i] = 0;
      end else if (ok && cmd == 2 && hit) begin
        m_act[i] = 1;
      end else if (ok && (cmd == 3 || cmd == 4) && hit) begin
        if (a) begin m_pend[i] = 1; m_cnt[i] = (bl == 0) ? 1 : bl; end
        else m_pend[i] = 0;
      end else if (m_pend[i]) begin
        if (m_cnt[i] <= 1) begin m_act[i] = 0; m_pend[i] = 0; end
        else m_cnt[i]--;
      end
      exp_act[i] = m_act[i];
    end
    m_ckep = ck;
    @(posedge clk); #1;
    chk(tag, "cmd_onehot", 32'(cmd_onehot), 32'(12'd1 << cmd));
    chk(tag, "cmd_bank", 32'(cmd_bank), 32'(b));
    chk(tag, "illegal", 32'(illegal), 32'(!ok));
    chk(tag, "autopre", 32'(autopre), 32'(exp_ap));
    chk(tag, "pre_all", 32'(pre_all), 32'(exp_pa));
    chk(tag, "bank_active", 32'(bank_active), 32'(exp_act));
  endtask

  task automatic nop(string tag);                 cyc(tag, 0, 1, 1, 1, 1, 0, 0, 0); endtask
  task automatic act(string tag, int b);          cyc(tag, 0, 0, 1, 1, 1, b, 0, 0); endtask
  task automatic rd(string tag, int b, bit a, int bl); cyc(tag, 0, 1, 0, 1, 1, b, a, bl); endtask
  task automatic wr(string tag, int b, bit a, int bl); cyc(tag, 0, 1, 0, 0, 1, b, a, bl); endtask
  task automatic pre(string tag, int b, bit a);   cyc(tag, 0, 0, 1, 0, 1, b, a, 0); endtask
  task automatic refa(string tag);                cyc(tag, 0, 0, 0, 1, 1, 0, 0, 0); endtask
  task automatic mrs(string tag);                 cyc(tag, 0, 0, 0, 0, 1, 0, 0, 0); endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5d2a_11c7));
    for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; end
    m_ckep = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11: reset state
    chk("R11", "cmd_onehot", 32'(cmd_onehot), 32'h2);
    chk("R11", "bank_active", 32'(bank_active), 32'h0);
    chk("R11", "illegal", 32'(illegal), 32'h0);
    chk("R11", "flags", 32'({autopre, pre_all}), 32'h0);

    refa("R9");                 // legal when idle
    mrs("R9");
    act("R5", 0);
    act("R5", 0);               // already open: illegal
    rd("R6", 1, 0, 0);          // idle bank
    wr("R6", 1, 1, 4);
    refa("R9");                 // illegal, bank 0 open
    mrs("R9");
    rd("R7", 0, 1, 3);          // countdown of 3
    nop("R7"); nop("R7"); nop("R7"); nop("R7");
    act("R8", 1); act("R8", 2); act("R8", 3);
    pre("R8", 1, 0);            // only bank 1
    pre("R8", 1, 0);            // idle bank precharge still legal
    pre("R8", 0, 1);            // all banks
    act("R10", 3);
    wr("R10", 3, 1, 5);
    nop("R10");
    rd("R10", 3, 0, 0);         // cancels countdown
    repeat (6) nop("R10");
    pre("R10", 3, 0);
    act("R10", 2);
    rd("R10", 2, 1, 4);
    pre("R10", 2, 0);           // precharge cancels too
    act("R10", 2);
    repeat (5) nop("R10");      // no stale countdown
    pre("R10", 0, 1);
    act("R7", 0);
    rd("R7", 0, 1, 0);          // zero count acts as one
    nop("R7");
    // R3: self-refresh entry while idle, held cycles ignore pins
    cyc("R3", 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R3", 0, 0, 1, 1, 0, 1, 0, 0);  // activate pins while held
    cyc("R3", 0, 0, 1, 1, 1, 1, 0, 0);  // exit edge, still held
    nop("R3");
    cyc("R3", 1, 1, 1, 1, 0, 0, 0, 0);  // power-down entry via deselect
    cyc("R3", 1, 1, 1, 1, 1, 0, 0, 0);
    act("R9", 2);
    cyc("R9", 0, 1, 1, 1, 0, 2, 0, 0);  // power-down while open: illegal
    cyc("R9", 0, 1, 1, 1, 1, 2, 0, 0);
    cyc("R9", 0, 0, 0, 1, 0, 0, 0, 0);  // self-refresh while open: illegal
    cyc("R9", 0, 0, 0, 1, 1, 0, 0, 0);
    cyc("R2", 1, 0, 1, 1, 1, 3, 1, 0);  // deselect with activate pins
    cyc("R2", 0, 1, 1, 0, 1, 1, 1, 0);  // burst stop
    pre("R2", 2, 1);

    // R1, R4: random traffic against the reference model
    for (int n = 0; n < 1500; n++) begin
      int  sel = int'($urandom_range(0, 9));
      bit  cs  = ($urandom_range(0, 9) == 0);
      bit  ck  = ($urandom_range(0, 11) != 0);
      int  b   = int'($urandom_range(0, 3));
      bit  a   = ($urandom_range(0, 2) == 0);
      int  bl  = int'($urandom_range(0, 6));
      logic [2:0] p;
      case (sel)
        0, 1: p = 3'b011;
        2, 3: p = 3'b101;
        4:    p = 3'b100;
        5, 6: p = 3'b010;
        7:    p = 3'b111;
        8:    p = 3'b001;
        default: p = 3'(($urandom_range(0, 7)));
      endcase
      cyc((n % 2) ? "R1" : "R4", cs, p[2], p[1], p[0], ck, b, a, bl);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule